// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two direction predictors side by side and letting a per-branch selector decide which of them to trust. The first predictor is local. Each branch has its own shift register of recent outcomes, and that history addresses a table of 2-bit saturating counters. The second predictor is global. One shift register holds the outcomes of the most recent branches of any kind, and it addresses a second counter table. A third table holds 2-bit selector counters, one per branch slot, which record which of the two predictors has been right more often for that branch.

The fetch stage presents a PC on the lookup port and, in the same cycle, receives the final direction, both component directions and the selector's choice. When the branch resolves, the back end presents the PC, the real outcome and the two component directions it saved at fetch. The tables and histories are written on the next clock edge. Updates are assumed to arrive in program order, and the global history is advanced only at resolve time.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every lookup returns local 0, global 0, selector 0 and final 0. Selector counters reset to 01, direction counters reset to 01 (weakly not-taken), and all histories reset to zero.
- R2: The final prediction equals the global prediction when the selector MSB for the branch is 1, and equals the local prediction when that MSB is 0. The selector MSB is output as `pred_use_global`.
- R3: The local prediction is the MSB of the local counter addressed by the branch's local history. That history is selected by PC bits [ALIGN+LPC_W-1:ALIGN]. On each update of the branch, the history shifts left and takes the actual outcome into bit 0.
- R4: The global prediction is the MSB of the global counter addressed by the global history register. That register shifts left and takes each resolved outcome into bit 0.
- R5: Direction counters increment on a taken outcome and decrement on a not-taken outcome. They saturate at 3 and at 0.
- R6: When the two saved component predictions differ, the branch's selector counter (PC bits [ALIGN+CPC_W-1:ALIGN]) increments if the global one matched the outcome and decrements otherwise. It saturates at 3 and at 0.
- R7: When the two saved component predictions are equal, the selector counter is left unchanged.
- R8: While `up_valid` is low, no table or history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC looked up at fetch |
| pred_taken | output | 1 | Final predicted direction |
| pred_local | output | 1 | Local component direction |
| pred_global | output | 1 | Global component direction |
| pred_use_global | output | 1 | Selector choice, 1 means global |
| up_valid | input | 1 | Resolve update strobe |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_local | input | 1 | Local direction saved at fetch |
| up_global | input | 1 | Global direction saved at fetch |

## Verification
The assertions check the global history shift, its hold while idle, the selector state just after reset and the selector's direction of motion on every cycle. They observe the selector through the lookup port whenever the looked-up branch is the one being updated. Counter saturation, the indexing of local counters by per-branch history, and a full sequence in which the selector swings from local to global and back again can only be shown by the bench's scenarios, which compare lookups against hand-derived values.

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
  parameter int PC_W    = 32,
  parameter int ALIGN   = 2,
  parameter int LPC_W   = 10,
  parameter int LHIST_W = 10,
  parameter int GHIST_W = 12,
  parameter int CPC_W   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  output logic            pred_use_global,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_local,
  input  logic            up_global
);
  localparam int LH_N = 1 << LPC_W;
  localparam int LC_N = 1 << LHIST_W;
  localparam int GC_N = 1 << GHIST_W;
  localparam int CH_N = 1 << CPC_W;

  logic [LHIST_W-1:0] lhist [LH_N];
  logic [1:0]         lcnt  [LC_N];
  logic [1:0]         gcnt  [GC_N];
  logic [1:0]         cho   [CH_N];
  logic [GHIST_W-1:0] ghr;

  wire [LPC_W-1:0] lk_li = lk_pc[ALIGN +: LPC_W];
  wire [CPC_W-1:0] lk_ci = lk_pc[ALIGN +: CPC_W];
  wire [LPC_W-1:0] up_li = up_pc[ALIGN +: LPC_W];
  wire [CPC_W-1:0] up_ci = up_pc[ALIGN +: CPC_W];
  wire [LHIST_W-1:0] up_hist = lhist[up_li];

  function automatic logic [1:0] step(input logic [1:0] c, input logic inc);
    if (inc) step = (c == 2'd3) ? c : c + 2'd1;
    else     step = (c == 2'd0) ? c : c - 2'd1;
  endfunction

  assign pred_local      = lcnt[lhist[lk_li]][1];
  assign pred_global     = gcnt[ghr][1];
  assign pred_use_global = cho[lk_ci][1];
  assign pred_taken      = pred_use_global ? pred_global : pred_local;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghr <= '0;
      for (int i = 0; i < LH_N; i++) lhist[i] <= '0;
      for (int i = 0; i < LC_N; i++) lcnt[i]  <= 2'b01;
      for (int i = 0; i < GC_N; i++) gcnt[i]  <= 2'b01;
      for (int i = 0; i < CH_N; i++) cho[i]   <= 2'b01;
    end else if (up_valid) begin
      lhist[up_li]  <= {up_hist[LHIST_W-2:0], up_taken};
      lcnt[up_hist] <= step(lcnt[up_hist], up_taken);
      gcnt[ghr]     <= step(gcnt[ghr], up_taken);
      ghr           <= {ghr[GHIST_W-2:0], up_taken};
      if (up_local != up_global)
        cho[up_ci] <= step(cho[up_ci], up_global == up_taken);
    end
  end
endmodule

// File: rtl/tournament_predictor_chk.sv
module tournament_predictor_chk #(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PC_W-1:0]    lk_pc,
  input logic               pred_use_global,
  input logic               up_valid,
  input logic [PC_W-1:0]    up_pc,
  input logic               up_taken,
  input logic               up_local,
  input logic               up_global,
  input logic [GHIST_W-1:0] ghr
);
  a_r4_ghr_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (ghr[0] == $past(up_taken)) && (ghr[GHIST_W-1:1] == $past(ghr[GHIST_W-2:0])));

  a_r8_ghr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghr));

  a_r1_sel_local_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pred_use_global);

  a_r7_agree_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_local == up_global && lk_pc == up_pc)
      |=> (!$stable(lk_pc) || $stable(pred_use_global)));

  a_r6_global_right_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_local != up_global && up_global == up_taken && lk_pc == up_pc && pred_use_global)
      |=> (!$stable(lk_pc) || pred_use_global));

  a_r6_local_right_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_local != up_global && up_local == up_taken && lk_pc == up_pc && !pred_use_global)
      |=> (!$stable(lk_pc) || !pred_use_global));
endmodule

bind tournament_predictor tournament_predictor_chk #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_use_global(pred_use_global),
  .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
  .up_local(up_local), .up_global(up_global), .ghr(ghr)
);

// File: tb/test_tournament_predictor.sv
module test_tournament_predictor;
  logic clk = 0, rst_n = 0;
  logic [31:0] lk_pc = '0, up_pc = '0;
  logic up_valid = 0, up_taken = 0, up_local = 0, up_global = 0;
  logic pred_taken, pred_local, pred_global, pred_use_global;
  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  tournament_predictor i_tournament_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken),
    .pred_local(pred_local), .pred_global(pred_global), .pred_use_global(pred_use_global),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_local(up_local), .up_global(up_global));

  typedef struct packed {
    logic [31:0] pc;
    logic tk, l, g, s, f;
  } vec_t;

  localparam logic [31:0] PA = 32'h100, PB = 32'h204, PC = 32'h308, PD = 32'h40c;

  // R3/R4/R2/R6 sequence: two branches, predictions derived by hand from the requirements
  localparam vec_t VEC [6] = '{
    '{PA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{PB, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{PB, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{PA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{PB, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{PB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; up_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk, input logic l, input logic g, input logic v);
    @(negedge clk);
    up_pc = pc; up_taken = tk; up_local = l; up_global = g; up_valid = v;
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic look(input logic [31:0] pc);
    lk_pc = pc; #1;
  endtask

  initial begin
    #(5ns * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    look(PB);
    chk("R1 local", pred_local, 1'b0);
    chk("R1 global", pred_global, 1'b0);
    chk("R1 select", pred_use_global, 1'b0);
    chk("R1 final", pred_taken, 1'b0);

    foreach (VEC[i]) begin
      @(negedge clk);
      look(VEC[i].pc);
      chk("R3 local", pred_local, VEC[i].l);
      chk("R4 global", pred_global, VEC[i].g);
      chk("R6 select", pred_use_global, VEC[i].s);
      chk("R2 final", pred_taken, VEC[i].f);
      up_pc = VEC[i].pc; up_taken = VEC[i].tk;
      up_local = pred_local; up_global = pred_global; up_valid = 1;
      @(negedge clk);
      up_valid = 0;
    end

    // R6/R7 selector motion and saturation on one branch
    do_reset();
    lk_pc = PC;
    upd(PC, 1, 0, 1, 1); look(PC); chk("R6 step to global", pred_use_global, 1'b1);
    upd(PC, 1, 0, 0, 1); look(PC); chk("R7 agree keeps", pred_use_global, 1'b1);
    upd(PC, 1, 0, 1, 1);
    upd(PC, 1, 0, 1, 1); look(PC); chk("R6 saturate high", pred_use_global, 1'b1);
    upd(PC, 1, 1, 0, 1); look(PC); chk("R6 down once", pred_use_global, 1'b1);
    upd(PC, 1, 1, 0, 1); look(PC); chk("R6 back to local", pred_use_global, 1'b0);
    look(PC); chk("R2 final follows local", pred_taken, pred_local);
    // R8 invalid update ignored
    upd(PC, 1, 0, 1, 0); look(PC); chk("R8 idle no change", pred_use_global, 1'b0);

    // R5 counters saturate at zero: history stays zero on not-taken
    do_reset();
    upd(PD, 0, 0, 0, 1);
    upd(PD, 0, 0, 0, 1);
    upd(PD, 0, 0, 0, 1);
    look(PD);
    chk("R5 local floor", pred_local, 1'b0);
    chk("R5 global floor", pred_global, 1'b0);
    upd(PD, 0, 0, 0, 0); look(PD);
    chk("R8 idle keeps local", pred_local, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule